// File: doc/BRIEF.md
# Command Mailbox Handshake Controller

This block lets a host hand offload commands to an embedded controller through one shared 8-bit mailbox byte and then wait for them to finish. A request carries a command value. Only its low four bits count, and each of those bits names one command. When the block accepts a request it sets those bits in the low nibble of the mailbox. It then waits until the controller side has cleared every one of them. A cycle counter bounds the wait. The high nibble of the same byte holds one error flag per command, at the command bit's position plus four. The controller side can raise and drop these flags.

When a request finishes, the block gives a one-cycle done pulse and exactly one of three results: success, error (the request bits cleared but a matching error flag is set), or timeout (request bits still pending when the window runs out). A separate single-bit write port turns offload mode on and off. Turning it on while the controller reports that it is not ready also pulses the controller's function-enable line low for one cycle, which restarts the controller.

Top module: `cmd_mbox_ctrl`

## Requirements
- R1: After reset the mailbox reads 0x00, busy, done and all three result flags are 0, offload mode is off and the controller function-enable output is 1.
- R2: A start seen while idle makes busy 1 from the next cycle. In the same edge it ORs cmd[3:0] into mailbox bits [3:0]. Bits cmd[7:4] are ignored and the other mailbox bits keep their values.
- R3: While busy, once every requested bit in mailbox[3:0] reads 0, done pulses for exactly one cycle on the following edge and busy drops. When the controller clears the bits in the first waiting cycle, done is seen at the second edge after that clear.
- R4: On completion the result is error (res_err=1, res_ok=0) if mailbox bit i+4 is set for any requested bit i. Otherwise the result is success (res_ok=1).
- R5: If a requested bit is still set after TIMEOUT_CYCLES waiting cycles, done pulses TIMEOUT_CYCLES edges after the accepting edge with res_tmo=1 and res_ok=0. The pending request bits stay set in the mailbox.
- R6: A start while busy is ignored: the mailbox low nibble is not changed and the running command mask is kept.
- R7: A write of 1 to the offload port sets offload_en. A write of 0 clears it. A write of 1 while ctrl_ready is 0 drives ctrl_func_en low for exactly one cycle and then high again. With ctrl_ready at 1, ctrl_func_en stays high.
- R8: The controller-side inputs clear mailbox request bits [3:0], set error bits [7:4] and clear error bits [7:4]. A host request bit set in the same edge as a controller clear of that bit wins.
- R9: Error flags at positions whose command bit was not requested do not change the result.
- R10: A request with cmd[3:0] = 0 completes with success on the first waiting edge, so done is seen one edge after the accepting edge.
- R11: The result flags hold their value after done until the next start is accepted, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a command issue (taken only when idle) |
| cmd | input | 8 | Command value; only bits [3:0] are used |
| busy | output | 1 | A command is waiting for completion |
| done | output | 1 | One-cycle pulse when a command finishes |
| res_ok | output | 1 | Last command succeeded |
| res_err | output | 1 | Last command completed with a matching error flag |
| res_tmo | output | 1 | Last command timed out |
| ctrl_clr_req | input | 4 | Controller clears these mailbox request bits |
| ctrl_set_err | input | 4 | Controller sets these mailbox error bits [7:4] |
| ctrl_clr_err | input | 4 | Controller clears these mailbox error bits [7:4] |
| mbox | output | 8 | Current mailbox byte |
| offload_wr | input | 1 | Write strobe for the offload-enable bit |
| offload_wdata | input | 1 | Value written to the offload-enable bit |
| ctrl_ready | input | 1 | Controller reports it is ready |
| offload_en | output | 1 | Offload mode enabled |
| ctrl_func_en | output | 1 | Controller function enable (low pulse restarts it) |

## Verification
The assertions take it that the controller side never sets a request bit itself, so a new 1 in the mailbox low nibble can only come from an accepted start. The bench keeps to this because it drives the controller inputs only as clears on the low nibble and as sets and clears on the high nibble. They also take it that all inputs change away from the clock edge and are 0 while reset is held. The bench drives every input on the falling edge and holds them at 0 from time zero until reset has been released.

// File: rtl/cmbx_pkg.sv
package cmbx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } cmbx_state_e;
endpackage

// File: rtl/cmbx_mailbox.sv
module cmbx_mailbox #(
  parameter int REQ_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REQ_W-1:0]   host_set,
  input  logic [REQ_W-1:0]   clr_req,
  input  logic [REQ_W-1:0]   set_err,
  input  logic [REQ_W-1:0]   clr_err,
  output logic [2*REQ_W-1:0] mbox_q
);
  localparam int MB_W = 2 * REQ_W;

  logic [MB_W-1:0] set_all;
  logic [MB_W-1:0] clr_all;
  logic [MB_W-1:0] mbox_d;

  assign set_all = {set_err, host_set};
  assign clr_all = {clr_err, clr_req};

  // each bit: a set in the same edge overrides a clear
  for (genvar b = 0; b < MB_W; b++) begin : g_bit
    always_comb begin
      mbox_d[b] = (mbox_q[b] & ~clr_all[b]) | set_all[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mbox_q <= '0;
    else        mbox_q <= mbox_d;
  end
endmodule

// File: rtl/cmbx_timer.sv
module cmbx_timer #(
  parameter int TIMEOUT_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = run ? cnt_q + 1'b1 : '0;
  end

  assign expired = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cmbx_offload_ctl.sv
module cmbx_offload_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  input  logic ready,
  output logic en_q,
  output logic func_en_q
);
  logic en_d;
  logic func_en_d;

  always_comb begin
    en_d      = en_q;
    func_en_d = 1'b1;
    if (wr) begin
      en_d = wdata;
      if (wdata && !ready) func_en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      func_en_q <= 1'b1;
    end else begin
      en_q      <= en_d;
      func_en_q <= func_en_d;
    end
  end
endmodule

// File: rtl/cmbx_fsm.sv
module cmbx_fsm
  import cmbx_pkg::*;
#(
  parameter int REQ_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [REQ_W-1:0]   req_mask,
  input  logic [2*REQ_W-1:0] mbox,
  input  logic               expired,
  output logic [REQ_W-1:0]   host_set,
  output logic               busy,
  output logic               done_q,
  output logic               ok_q,
  output logic               err_q,
  output logic               tmo_q
);
  cmbx_state_e      state_q, state_d;
  logic [REQ_W-1:0] mask_q;
  logic             mask_en;
  logic             done_d, ok_d, err_d, tmo_d;
  logic             pending, flagged;

  assign pending = |(mbox[REQ_W-1:0] & mask_q);
  assign flagged = |(mbox[2*REQ_W-1:REQ_W] & mask_q);
  assign busy    = (state_q == ST_WAIT);

  always_comb begin
    state_d  = state_q;
    mask_en  = 1'b0;
    host_set = '0;
    done_d   = 1'b0;
    ok_d     = ok_q;
    err_d    = err_q;
    tmo_d    = tmo_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_WAIT;
          mask_en  = 1'b1;
          host_set = req_mask;
          ok_d     = 1'b0;
          err_d    = 1'b0;
          tmo_d    = 1'b0;
        end
      end
      ST_WAIT: begin
        if (!pending) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          ok_d    = !flagged;
          err_d   = flagged;
        end else if (expired) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          tmo_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (mask_en) mask_q <= req_mask;
      done_q  <= done_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
      tmo_q   <= tmo_d;
    end
  end
endmodule

// File: rtl/cmd_mbox_ctrl.sv
module cmd_mbox_ctrl #(
  parameter int CMD_W          = 8,
  parameter int REQ_W          = 4,
  parameter int TIMEOUT_CYCLES = 50_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CMD_W-1:0]   cmd,
  output logic               busy,
  output logic               done,
  output logic               res_ok,
  output logic               res_err,
  output logic               res_tmo,
  input  logic [REQ_W-1:0]   ctrl_clr_req,
  input  logic [REQ_W-1:0]   ctrl_set_err,
  input  logic [REQ_W-1:0]   ctrl_clr_err,
  output logic [2*REQ_W-1:0] mbox,
  input  logic               offload_wr,
  input  logic               offload_wdata,
  input  logic               ctrl_ready,
  output logic               offload_en,
  output logic               ctrl_func_en
);
  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic [REQ_W-1:0] req_mask;
  logic [REQ_W-1:0] host_set;
  logic             expired;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign req_mask = cmd[REQ_W-1:0];

  cmbx_mailbox #(.REQ_W(REQ_W)) u_mbox (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .host_set (host_set),
    .clr_req  (ctrl_clr_req),
    .set_err  (ctrl_set_err),
    .clr_err  (ctrl_clr_err),
    .mbox_q   (mbox)
  );

  cmbx_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .run     (busy),
    .expired (expired)
  );

  cmbx_fsm #(.REQ_W(REQ_W)) u_fsm (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .start    (start),
    .req_mask (req_mask),
    .mbox     (mbox),
    .expired  (expired),
    .host_set (host_set),
    .busy     (busy),
    .done_q   (done),
    .ok_q     (res_ok),
    .err_q    (res_err),
    .tmo_q    (res_tmo)
  );

  cmbx_offload_ctl u_ofl (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .wr        (offload_wr),
    .wdata     (offload_wdata),
    .ready     (ctrl_ready),
    .en_q      (offload_en),
    .func_en_q (ctrl_func_en)
  );
endmodule

// File: rtl/cmd_mbox_ctrl_chk.sv
module cmd_mbox_ctrl_chk #(
  parameter int REQ_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               res_ok,
  input logic               res_err,
  input logic               res_tmo,
  input logic [2*REQ_W-1:0] mbox,
  input logic               offload_en,
  input logic               ctrl_func_en
);
  // R3 R4 R5
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({res_ok, res_err, res_tmo}) == 1));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R6
  req_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mbox[REQ_W-1:0] & ~$past(mbox[REQ_W-1:0]))) |-> $past(start && !busy));

  // R7
  func_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_func_en) |=> ctrl_func_en);

  // R7
  func_low_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_func_en) |-> offload_en);
endmodule

bind cmd_mbox_ctrl cmd_mbox_ctrl_chk #(.REQ_W(REQ_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .res_ok       (res_ok),
  .res_err      (res_err),
  .res_tmo      (res_tmo),
  .mbox         (mbox),
  .offload_en   (offload_en),
  .ctrl_func_en (ctrl_func_en)
);

// File: tb/cmd_mbox_ctrl_test.sv
module cmd_mbox_ctrl_test;
  localparam int TMO = 20;
  localparam int NV  = 8;
  // entry: {cmd[7:0], controller responds, error bits raised with the response}
  localparam logic [12:0] VEC [NV] = '{
    {8'h01, 1'b1, 4'h0},
    {8'hF3, 1'b1, 4'h0},
    {8'h02, 1'b1, 4'h2},
    {8'h01, 1'b1, 4'h2},
    {8'h08, 1'b0, 4'h0},
    {8'h00, 1'b1, 4'hF},
    {8'h0C, 1'b1, 4'h8},
    {8'h05, 1'b0, 4'h0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] cmd = '0;
  logic       busy, done, res_ok, res_err, res_tmo;
  logic [3:0] ctrl_clr_req = '0;
  logic [3:0] ctrl_set_err = '0;
  logic [3:0] ctrl_clr_err = '0;
  logic [7:0] mbox;
  logic       offload_wr = 1'b0;
  logic       offload_wdata = 1'b0;
  logic       ctrl_ready = 1'b0;
  logic       offload_en, ctrl_func_en;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cmd_mbox_ctrl #(.TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
    .busy(busy), .done(done), .res_ok(res_ok), .res_err(res_err), .res_tmo(res_tmo),
    .ctrl_clr_req(ctrl_clr_req), .ctrl_set_err(ctrl_set_err), .ctrl_clr_err(ctrl_clr_err),
    .mbox(mbox), .offload_wr(offload_wr), .offload_wdata(offload_wdata),
    .ctrl_ready(ctrl_ready), .offload_en(offload_en), .ctrl_func_en(ctrl_func_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic clean_mbox();
    @(negedge clk);
    ctrl_clr_req = 4'hF;
    ctrl_clr_err = 4'hF;
    @(negedge clk);
    ctrl_clr_req = '0;
    ctrl_clr_err = '0;
  endtask

  // poll from the negedge after the accepting edge; returns negedge index of done
  task automatic wait_done(output int n);
    n = 1;
    do begin
      @(negedge clk);
      n++;
      ctrl_clr_req = '0;
      ctrl_set_err = '0;
      start = 1'b0;
    end while (!done && n < 5 * TMO);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all R) actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 mbox", int'(mbox), 0);
    chk("R1 busy/done", int'({busy, done}), 0);
    chk("R1 results", int'({res_ok, res_err, res_tmo}), 0);
    chk("R1 offload_en", int'(offload_en), 0);
    chk("R1 func_en", int'(ctrl_func_en), 1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [3:0] m;
      logic       rsp;
      logic [3:0] eb;
      int         exp_n;
      m   = VEC[v][12:9] == 4'h0 ? VEC[v][8:5] : VEC[v][8:5];
      m   = VEC[v][8:5];
      rsp = VEC[v][4];
      eb  = VEC[v][3:0];
      start = 1'b1;
      cmd   = VEC[v][12:5];
      @(negedge clk);
      start = 1'b0;
      chk($sformatf("R2 vec%0d mbox low", v), int'(mbox[3:0]), int'(m));
      chk($sformatf("R2 vec%0d mbox high", v), int'(mbox[7:4]), 0);
      chk($sformatf("R2 vec%0d busy", v), int'(busy), 1);
      if (rsp) begin
        ctrl_clr_req = m;
        ctrl_set_err = eb;
      end
      wait_done(n);
      if (m == 4'h0) begin
        exp_n = 2;                                  // R10
        chk($sformatf("R10 vec%0d cycles", v), n, exp_n);
        chk($sformatf("R10 vec%0d ok", v), int'(res_ok), 1);
      end else if (!rsp) begin
        exp_n = TMO + 1;                            // R5
        chk($sformatf("R5 vec%0d cycles", v), n, exp_n);
        chk($sformatf("R5 vec%0d flags", v), int'({res_ok, res_err, res_tmo}), 1);
        chk($sformatf("R5 vec%0d pending bits", v), int'(mbox[3:0]), int'(m));
      end else begin
        exp_n = 3;                                  // R3
        chk($sformatf("R3 vec%0d cycles", v), n, exp_n);
        if ((eb & m) != 4'h0)
          chk($sformatf("R4 vec%0d flags", v), int'({res_ok, res_err, res_tmo}), 2);
        else
          chk($sformatf("R9 R4 vec%0d flags", v), int'({res_ok, res_err, res_tmo}), 4);
      end
      @(negedge clk);
      chk($sformatf("R3 vec%0d done pulse", v), int'(done), 0);
      chk($sformatf("R11 vec%0d held", v), int'(res_ok | res_err | res_tmo), 1);
      clean_mbox();
    end

    // R6 start while busy ignored
    start = 1'b1;
    cmd   = 8'h01;
    @(negedge clk);
    cmd = 8'h02;                 // still start=1 while busy
    @(negedge clk);
    start = 1'b0;
    chk("R6 mbox low unchanged", int'(mbox[3:0]), 1);
    ctrl_clr_req = 4'h1;
    wait_done(n);
    chk("R6 mask kept, completes", int'({res_ok, res_err, res_tmo}), 4);
    // R11 next accept clears results
    start = 1'b1;
    cmd   = 8'h04;
    ctrl_clr_req = 4'h4;         // R8 same-edge clear loses to host set
    @(negedge clk);
    start = 1'b0;
    ctrl_clr_req = '0;
    chk("R11 results cleared on accept", int'({res_ok, res_err, res_tmo}), 0);
    chk("R8 host set wins", int'(mbox[2]), 1);
    ctrl_clr_req = 4'h4;
    wait_done(n);
    chk("R8 completes after clear", int'(res_ok), 1);
    clean_mbox();

    // R8 error bits set and cleared by controller
    @(negedge clk);
    ctrl_set_err = 4'hA;
    @(negedge clk);
    ctrl_set_err = '0;
    chk("R8 error set", int'(mbox), 8'hA0);
    ctrl_clr_err = 4'h2;
    @(negedge clk);
    ctrl_clr_err = '0;
    chk("R8 error clear", int'(mbox), 8'h80);
    clean_mbox();

    // R7 offload enable with controller not ready
    ctrl_ready    = 1'b0;
    offload_wr    = 1'b1;
    offload_wdata = 1'b1;
    @(negedge clk);
    offload_wr = 1'b0;
    chk("R7 offload on", int'(offload_en), 1);
    chk("R7 func_en low", int'(ctrl_func_en), 0);
    @(negedge clk);
    chk("R7 func_en back high", int'(ctrl_func_en), 1);
    offload_wr    = 1'b1;
    offload_wdata = 1'b0;
    @(negedge clk);
    offload_wr = 1'b0;
    chk("R7 offload off", int'(offload_en), 0);
    chk("R7 func_en high on disable", int'(ctrl_func_en), 1);
    ctrl_ready    = 1'b1;
    offload_wr    = 1'b1;
    offload_wdata = 1'b1;
    @(negedge clk);
    offload_wr = 1'b0;
    chk("R7 ready: offload on", int'(offload_en), 1);
    chk("R7 ready: func_en stays", int'(ctrl_func_en), 1);
    @(negedge clk);
    chk("R7 ready: func_en stays 2", int'(ctrl_func_en), 1);

    // R1 reset mid-operation
    start = 1'b1;
    cmd   = 8'h03;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 async reset mbox", int'(mbox), 0);
    chk("R1 async reset offload", int'({busy, offload_en, ctrl_func_en}), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    summary();
    $finish;
  end
endmodule